// File: doc/BRIEF.md
# Peripheral Event Flag Register

This block gathers event pulses from seven peripheral sources into one 8-bit flag register. A software bus reads and writes it. It also drives a single interrupt request line. Five of the flags are sticky. Hardware sets one of them on an event pulse, and it stays set until software writes 0 to it. Software may also write 1 to set such a flag, which lets firmware raise an interrupt as a test. The two serial flags have no storage. They mirror two status levels: receive data waiting and transmit holding buffer empty. Software clears them by accessing the matching buffer, not by writing this register.

A flag records its event whatever its enable bit or the global enable is set to. The request output is raised when some flag is set, its enable bit is set and the global enable is high.

Top module: `evt_flag_reg`

## Requirements
- R1: After reset is asserted (rst_n low), every bit of rd_data reads 0 and irq_o is 0.
- R2: Bit map, MSB to LSB: bit 7 parallel-port access, bit 6 conversion done, bit 5 receive data waiting, bit 4 transmit buffer empty, bit 3 sync-serial done, bit 2 unused, bit 1 timer-B period match, bit 0 timer-A overflow. The event pulse inputs use the same positions.
- R3: A one-cycle event pulse on a sticky source (bits 7, 6, 3, 1, 0) sets that flag on the next clock edge. The flag is set whatever the enable inputs are.
- R4: A sticky flag stays set until software writes 0 to its bit with a bus write.
- R5: A bus write of 1 to a sticky bit sets that flag.
- R6: If an event pulse and a software write of 0 reach the same sticky flag in the same cycle, the flag ends up set.
- R7: Bit 5 equals the rx_full input level, and bus writes do not change it.
- R8: Bit 4 equals the tx_empty input level, and bus writes do not change it.
- R9: Bit 2 always reads 0, including after a bus write of 1 to it.
- R10: irq_o is high exactly when glb_en is high and (rd_data & en_i) is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Current flag values |
| evt_i | input | 8 | Event pulses, one per bit position (only sticky positions used) |
| rx_full | input | 1 | Receive buffer holds data (level) |
| tx_empty | input | 1 | Transmit buffer empty (level) |
| en_i | input | 8 | Per-bit interrupt enables |
| glb_en | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A sticky flag with a wrong internal state shows on rd_data in the first cycle after the faulty edge. If the flag is enabled, it also shows on irq_o in that cycle, because the request logic is purely combinational from the flags. The bench drives each set, clear and collision case one cycle at a time. It samples on the next falling edge, so a lost event or a failed clear is seen within one cycle. Errors in the live mirror bits and the unused bit show in the same cycle as the input change.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
  localparam int FLAG_W = 8;
  localparam int POS_PSP = 7;
  localparam int POS_ADC = 6;
  localparam int POS_RX  = 5;
  localparam int POS_TX  = 4;
  localparam int POS_SSP = 3;
  localparam int POS_NU  = 2;
  localparam int POS_TMB = 1;
  localparam int POS_TMA = 0;

  typedef enum logic [1:0] {
    KIND_STICKY = 2'd0,
    KIND_MIRROR = 2'd1,
    KIND_ZERO   = 2'd2
  } bit_kind_e;

  function automatic bit_kind_e kind_of(input int pos);
    if (pos == POS_RX || pos == POS_TX) return KIND_MIRROR;
    if (pos == POS_NU) return KIND_ZERO;
    return KIND_STICKY;
  endfunction
endpackage

// File: rtl/evt_sticky_bit.sv
module evt_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  logic q_nx;
  logic q_ce;

  always_comb begin
    q_ce = evt | wr_en;
    if (evt) q_nx = 1'b1;
    else     q_nx = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_ce) q <= q_nx;
  end

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> q); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && wr_en && !wr_val) |=> q); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !wr_en) |=> $stable(q)); // R4
  AST_WR_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && wr_en && !wr_val) |=> !q); // R4
  AST_WR_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val) |=> q); // R5
endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
  parameter int W = 8
) (
  input  logic [W-1:0] flags,
  input  logic [W-1:0] en,
  input  logic         glb_en,
  output logic         irq
);
  always_comb irq = glb_en & (|(flags & en));
endmodule

// File: rtl/evt_flag_reg.sv
module evt_flag_reg
  import evt_flag_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] evt_i,
  input  logic         rx_full,
  input  logic         tx_empty,
  input  logic [W-1:0] en_i,
  input  logic         glb_en,
  output logic         irq_o
);
  logic [W-1:0] flag_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (kind_of(g) == KIND_STICKY) begin : g_sticky
      evt_sticky_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_i[g]),
        .wr_en  (wr_en),
        .wr_val (wr_data[g]),
        .q      (flag_q[g])
      );
    end else if (kind_of(g) == KIND_MIRROR) begin : g_mirror
      if (g == POS_RX) begin : g_rx
        always_comb flag_q[g] = rx_full & rst_n;
      end else begin : g_tx
        always_comb flag_q[g] = tx_empty & rst_n;
      end
    end else begin : g_zero
      always_comb flag_q[g] = 1'b0;
    end
  end

  always_comb rd_data = flag_q;

  evt_irq_combine #(.W(W)) u_irq (
    .flags  (flag_q),
    .en     (en_i),
    .glb_en (glb_en),
    .irq    (irq_o)
  );

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[POS_NU] == 1'b0); // R9
  AST_RX_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[POS_RX] == rx_full); // R7
  AST_TX_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[POS_TX] == tx_empty); // R8
  AST_NO_GLB_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_o); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_data & ~((W'(1) << POS_RX) | (W'(1) << POS_TX))) == '0); // R1
endmodule

// File: tb/evt_flag_reg_bench.sv
module evt_flag_reg_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] evt_i;
  logic rx_full, tx_empty;
  logic [7:0] en_i;
  logic glb_en;
  logic irq_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  evt_flag_reg u_evt_flag_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_i(evt_i), .rx_full(rx_full),
    .tx_empty(tx_empty), .en_i(en_i), .glb_en(glb_en), .irq_o(irq_o)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse(input logic [7:0] e);
    evt_i = e;
    step();
    evt_i = 8'h00;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 0; wr_data = 0; evt_i = 0;
    rx_full = 0; tx_empty = 0; en_i = 8'hFF; glb_en = 1;
    step(); step();
    chk8("R1 rd", rd_data, 8'h00);
    chk8("R1 irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    step();
    chk8("R1 after release", rd_data, 8'h00);
  endtask

  task automatic t_events_disabled();
    en_i = 8'h00; glb_en = 0;
    pulse(8'b1100_1011);
    chk8("R3 R2 set with enables off", rd_data, 8'b1100_1011);
    chk8("R10 no irq when disabled", {7'd0, irq_o}, 8'h00);
    step();
    chk8("R4 flags held", rd_data, 8'b1100_1011);
  endtask

  task automatic t_clear();
    bus_wr(8'b1100_1001);
    chk8("R4 clear bit1", rd_data, 8'b1100_1001);
    bus_wr(8'h00);
    chk8("R4 clear all", rd_data, 8'h00);
  endtask

  task automatic t_wr_one();
    bus_wr(8'b0000_1000);
    chk8("R5 write one sets", rd_data, 8'b0000_1000);
    bus_wr(8'h00);
  endtask

  task automatic t_collision();
    evt_i = 8'b0100_0000; wr_en = 1; wr_data = 8'h00;
    step();
    evt_i = 0; wr_en = 0;
    chk8("R6 set beats clear", rd_data, 8'b0100_0000);
    bus_wr(8'h00);
    chk8("R6 later clear", rd_data, 8'h00);
  endtask

  task automatic t_mirror();
    rx_full = 1; #1;
    chk8("R7 rx follows", rd_data, 8'b0010_0000);
    bus_wr(8'h00);
    chk8("R7 write 0 no effect", rd_data, 8'b0010_0000);
    rx_full = 0; tx_empty = 1; #1;
    chk8("R8 tx follows", rd_data, 8'b0001_0000);
    bus_wr(8'h00);
    chk8("R8 write 0 no effect", rd_data, 8'b0001_0000);
    tx_empty = 0;
    bus_wr(8'b0011_0000);
    chk8("R7 R8 write 1 no effect", rd_data, 8'h00);
  endtask

  task automatic t_unused();
    bus_wr(8'b0000_0100);
    chk8("R9 unused bit", rd_data, 8'h00);
    pulse(8'b0000_0100);
    chk8("R9 unused event", rd_data, 8'h00);
  endtask

  task automatic t_irq();
    pulse(8'b0000_0001);
    en_i = 8'b0000_0010; glb_en = 1; #1;
    chk8("R10 enable mismatch", {7'd0, irq_o}, 8'h00);
    en_i = 8'b0000_0001; #1;
    chk8("R10 enabled", {7'd0, irq_o}, 8'h01);
    glb_en = 0; #1;
    chk8("R10 global off", {7'd0, irq_o}, 8'h00);
    glb_en = 1; bus_wr(8'h00);
    chk8("R10 cleared", {7'd0, irq_o}, 8'h00);
    tx_empty = 1; en_i = 8'b0001_0000; #1;
    chk8("R10 R8 tx irq", {7'd0, irq_o}, 8'h01);
    tx_empty = 0; #1;
  endtask

  initial begin
    t_reset();
    t_events_disabled();
    t_clear();
    t_wr_one();
    t_collision();
    t_mirror();
    t_unused();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule